// File: doc/BRIEF.md
# Pin-Selectable Level Interrupt Unit

This block turns GPIO pin levels into interrupt requests. It has eight channels. Each channel reads one pin. A 4-bit group select per channel chooses which pin group supplies that pin. A 3-bit trigger code per channel decides whether a high level, a low level or nothing raises the channel's pending bit. Pending bits stay set until software clears them with a write-one-to-clear acknowledge. A mask register gates the pending bits onto a single registered interrupt line.

Two further pending bits take done events from neighbouring peripherals. They share the mask, status and acknowledge registers with the GPIO channels. Every register is reached over a plain synchronous register bus. A write takes effect on the clock edge where the write strobe is high. A read returns data combinationally from the current address.

Pin groups are laid out so that group g, channel n, is pin `g*8 + n`. Pins first pass through a two-flop synchronizer, so asynchronous pads can drive the block directly.

Top module: `pin_irq_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_o` is low.
- R2: The register addresses are as follows:
  - 0: trigger configuration, 24 bits, channel n at bits [3n+2:3n].
  - 1: group select, 32 bits, channel n at bits [4n+3:4n].
  - 2: mask, 10 bits.
  - 3: raw pending status.
  - 4: masked status.
  - 5: acknowledge, write only, reads 0.
  - 6 and 7 read 0.
- R3: Trigger code 1 fires while the selected pin is 1. Code 2 fires while it is 0. Codes 0 and 3 to 7 never fire.
- R4: Channel n with group select g reads input pin `g*8 + n`.
- R5: A group select of 12 or above names no pin group, and the channel then reads 0.
- R6: A pending bit stays set after its cause goes away. It clears only when 1 is written to the same bit of the acknowledge register. Writing 0 to that bit has no effect.
- R7: If a trigger fires in the same cycle as the acknowledge of its bit, the bit stays pending.
- R8: Masked status equals raw status ANDed with the mask. Mask bits 7:0 cover the channels, and mask bits 9:8 cover the done events.
- R9: While `ext_done_i[k]` is high, pending bit 8+k is set. This input has no synchronizer, so its bit sets at the next edge.
- R10: `irq_o` is the OR of the masked status, registered once. A pin change is visible in raw status 3 clock edges after it is applied, and on `irq_o` 4 edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| pins_i | input | 96 | GPIO input pins, 12 groups of 8 |
| ext_done_i | input | 2 | Done events from external peripherals |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong pending bit appears in raw status on the next bus read. It reaches `irq_o` one edge later if its mask bit is set. A wrong group select or trigger decode shows up as a raw status that does not match the pin pattern. That mismatch is visible three edges after the pins settle, because of the synchronizer and the pending register. A broken acknowledge priority shows as a bit that clears while its level is still present, or one that survives a matching write. Either case appears on the read right after the acknowledge edge.

// File: rtl/piu_pkg.sv
package piu_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int TRIG_W = 3;
    localparam int SEL_W  = 4;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2
    } trig_code_e;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CFG   = 3'd0,
        ADDR_SEL   = 3'd1,
        ADDR_MASK  = 3'd2,
        ADDR_RAW   = 3'd3,
        ADDR_MSTAT = 3'd4,
        ADDR_ACK   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic trig_fire(input logic [TRIG_W-1:0] code, input logic lvl);
        case (code)
            TRIG_HIGH: return lvl;
            TRIG_LOW:  return !lvl;
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/piu_sync.sv
module piu_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/piu_chan.sv
module piu_chan
    import piu_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int NUM_GROUPS = 12,
    parameter int IDX        = 0,
    localparam int PIN_W     = NUM_CH * NUM_GROUPS
) (
    input  logic [PIN_W-1:0]  pins_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [TRIG_W-1:0] code_i,
    output logic              fire_o
);
    logic lvl;

    // group g feeds pin g*NUM_CH+IDX; unmatched selects leave lvl at 0
    always_comb begin
        lvl = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (sel_i == SEL_W'(g)) lvl = pins_i[g*NUM_CH + IDX];
        end
    end

    assign fire_o = trig_fire(code_i, lvl);
endmodule

// File: rtl/piu_pending.sv
module piu_pending #(
    parameter int N = 10
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    // set dominates acknowledge on the same bit
    always_ff @(posedge clk_i) begin
        if (rst_i) pend_q <= '0;
        else       pend_q <= (pend_q & ~ack_i) | set_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import piu_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int NUM_GROUPS = 12,
    parameter int NUM_EXT    = 2,
    localparam int PIN_W     = NUM_CH * NUM_GROUPS,
    localparam int NPEND     = NUM_CH + NUM_EXT,
    localparam int CFG_W     = NUM_CH * TRIG_W,
    localparam int SELV_W    = NUM_CH * SEL_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               reg_we_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [PIN_W-1:0]   pins_i,
    input  logic [NUM_EXT-1:0] ext_done_i,
    output logic               irq_o
);
    bus_req_t          req;
    logic [CFG_W-1:0]  cfg_q;
    logic [SELV_W-1:0] sel_q;
    logic [NPEND-1:0]  mask_q;
    logic [NPEND-1:0]  ack_vec;
    logic [NPEND-1:0]  set_vec;
    logic [NPEND-1:0]  pend_q;
    logic [NUM_CH-1:0] fire;
    logic [PIN_W-1:0]  pins_s;
    logic              irq_q;

    assign req = '{we: reg_we_i, addr: reg_addr_i, wdata: reg_wdata_i};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q  <= '0;
            sel_q  <= '0;
            mask_q <= '0;
        end else if (req.we) begin
            case (req.addr)
                ADDR_CFG:  cfg_q  <= req.wdata[CFG_W-1:0];
                ADDR_SEL:  sel_q  <= req.wdata[SELV_W-1:0];
                ADDR_MASK: mask_q <= req.wdata[NPEND-1:0];
                default: ;
            endcase
        end
    end

    assign ack_vec = (req.we && req.addr == ADDR_ACK) ? req.wdata[NPEND-1:0] : '0;

    piu_sync #(.W(PIN_W)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (pins_i),
        .q_o   (pins_s)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
        piu_chan #(.NUM_CH(NUM_CH), .NUM_GROUPS(NUM_GROUPS), .IDX(n)) u_chan (
            .pins_i (pins_s),
            .sel_i  (sel_q[n*SEL_W +: SEL_W]),
            .code_i (cfg_q[n*TRIG_W +: TRIG_W]),
            .fire_o (fire[n])
        );
    end

    assign set_vec = {ext_done_i, fire};

    piu_pending #(.N(NPEND)) u_pend (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (set_vec),
        .ack_i  (ack_vec),
        .pend_o (pend_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_q <= 1'b0;
        else       irq_q <= |(pend_q & mask_q);
    end
    assign irq_o = irq_q;

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CFG:   reg_rdata_o = DATA_W'(cfg_q);
            ADDR_SEL:   reg_rdata_o = DATA_W'(sel_q);
            ADDR_MASK:  reg_rdata_o = DATA_W'(mask_q);
            ADDR_RAW:   reg_rdata_o = DATA_W'(pend_q);
            ADDR_MSTAT: reg_rdata_o = DATA_W'(pend_q & mask_q);
            default: ;
        endcase
    end
endmodule

// File: rtl/piu_checker.sv
module piu_checker #(
    parameter int NPEND = 10
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [NPEND-1:0] pend_i,
    input logic [NPEND-1:0] mask_i,
    input logic [NPEND-1:0] ack_i,
    input logic [NPEND-1:0] set_i,
    input logic             irq_i
);
    assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!irq_i && pend_i == '0));

    assert_irq_follow_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |-> (irq_i == |($past(pend_i) & $past(mask_i))));

    assert_sticky_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (($past(pend_i) & ~$past(ack_i) & ~pend_i) == '0));

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (($past(set_i) & ~pend_i) == '0));

    assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((pend_i & ~$past(pend_i) & ~$past(set_i)) == '0));
endmodule

bind pin_irq_unit piu_checker #(.NPEND(NPEND)) u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .pend_i (pend_q),
    .mask_i (mask_q),
    .ack_i  (ack_vec),
    .set_i  (set_vec),
    .irq_i  (irq_o)
);

// File: tb/pin_irq_unit_tb.sv
`timescale 1ns/1ps
module pin_irq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [95:0] pins = '0;
    logic [1:0]  ext = '0;
    logic        irq;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pin_irq_unit dut_i (
        .clk_i(clk), .rst_i(rst), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pins_i(pins),
        .ext_done_i(ext), .irq_o(irq)
    );

    typedef struct packed {
        logic [23:0] cfg;
        logic [31:0] sel;
        logic [9:0]  mask;
        logic [95:0] pins;
        logic [9:0]  raw;
        logic [9:0]  mst;
        logic        irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{24'h249249, 32'h00000000, 10'h0FF, 96'hA5, 10'h0A5, 10'h0A5, 1'b1},
        '{24'h492492, 32'h00000000, 10'h00F, 96'hA5, 10'h05A, 10'h00A, 1'b1},
        '{24'h249249, 32'h11111111, 10'h0C3, 96'h3CFF, 10'h03C, 10'h000, 1'b0},
        '{24'h249249, 32'h76543210, 10'h0FF, 96'h00000000_80000000_00040001, 10'h085, 10'h085, 1'b1},
        '{24'h492492, 32'hFFFFFFFF, 10'h001, {96{1'b1}}, 10'h0FF, 10'h001, 1'b1},
        '{24'h0007D1, 32'h00000000, 10'h0FF, {96{1'b1}}, 10'h001, 10'h001, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic clean();
        wr(3'd0, 32'h0);
        wr(3'd5, 32'h3FF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        // R2 readback and field widths
        wr(3'd0, 32'hFFABCDEF); rd(3'd0, v); check("R2 cfg readback", v, 32'h00ABCDEF);
        wr(3'd1, 32'hDEADBEEF); rd(3'd1, v); check("R2 sel readback", v, 32'hDEADBEEF);
        wr(3'd2, 32'hFFFFFFFF); rd(3'd2, v); check("R2 mask readback", v, 32'h000003FF);
        rd(3'd5, v); check("R2 ack reads 0", v, 32'h0);
        rd(3'd7, v); check("R2 unused addr", v, 32'h0);
        clean();

        // R3 R4 R5 R8 table walk
        foreach (VECS[i]) begin
            clean();
            wr(3'd1, VECS[i].sel);
            wr(3'd2, 32'(VECS[i].mask));
            pins = VECS[i].pins;
            repeat (4) @(negedge clk);
            wr(3'd0, 32'(VECS[i].cfg));
            repeat (3) @(negedge clk);
            rd(3'd3, v); check($sformatf("R3 R4 R5 raw vec%0d", i), v, 32'(VECS[i].raw));
            rd(3'd4, v); check($sformatf("R8 masked vec%0d", i), v, 32'(VECS[i].mst));
            check($sformatf("R10 irq vec%0d", i), {31'h0, irq}, {31'h0, VECS[i].irq});
        end

        // R10 latency, R6 sticky and acknowledge
        pins = '0;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h001);
        repeat (4) @(negedge clk);
        wr(3'd5, 32'h3FF);
        wr(3'd0, 32'h1);
        @(negedge clk);
        pins[0] = 1'b1;
        repeat (2) @(negedge clk);
        rd(3'd3, v); check("R10 raw not yet at 2 edges", v, 32'h0);
        @(negedge clk);
        rd(3'd3, v); check("R10 raw at 3 edges", v, 32'h1);
        check("R10 irq not yet at 3 edges", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R10 irq at 4 edges", {31'h0, irq}, 32'h1);
        pins[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd3, v); check("R6 sticky after level gone", v, 32'h1);
        wr(3'd5, 32'h3FE);
        rd(3'd3, v); check("R6 ack with 0 no effect", v, 32'h1);
        wr(3'd5, 32'h001);
        rd(3'd3, v); check("R6 ack clears", v, 32'h0);
        @(negedge clk);
        check("R10 irq drops after ack", {31'h0, irq}, 32'h0);

        // R7 trigger wins over acknowledge
        pins[0] = 1'b1;
        repeat (4) @(negedge clk);
        wr(3'd5, 32'h001);
        rd(3'd3, v); check("R7 set wins over ack", v, 32'h1);
        pins[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R9 done events
        clean();
        wr(3'd2, 32'h100);
        ext = 2'b10;
        @(negedge clk);
        ext = 2'b00;
        rd(3'd3, v); check("R9 done1 raw", v, 32'h200);
        rd(3'd4, v); check("R9 done1 masked off", v, 32'h0);
        @(negedge clk);
        check("R9 irq stays low", {31'h0, irq}, 32'h0);
        ext = 2'b01;
        @(negedge clk);
        ext = 2'b00;
        rd(3'd3, v); check("R9 done0 raw", v, 32'h300);
        rd(3'd4, v); check("R9 done0 masked", v, 32'h100);
        @(negedge clk);
        check("R9 irq from done0", {31'h0, irq}, 32'h1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule